// File: doc/BRIEF.md
# Stream Deinterleaver With Channel Enables

The block receives packed words over a valid/ready stream. Each word carries one sample for every channel. The block hands those samples out to a set of channel output ports. On the read side there is one read strobe for all ports, and a per-channel enable mask. When a read is served, the enabled channels each take the next sample from the stream. The lowest enabled channel index takes the oldest sample. Disabled channels are skipped and take nothing.

Samples wait in a small internal buffer of twice the channel count. A read is answered one cycle later on one of two shared flags:
- the valid flag, when enough samples were buffered to serve every enabled channel;
- the underflow flag, when there were not, in which case the read removes nothing.

Back-pressure on the input is simple. `s_ready` is high only while the buffer has room for one whole input word. A word is taken on every clock edge where `s_valid` and `s_ready` are both high. The source must hold `s_valid` and `s_data` stable until that edge.

Top module: `stream_deinterleaver`

## Requirements
- R1: An input word is accepted at a rising edge where `s_valid` and `s_ready` are both high. Sample i of the word sits in `s_data[i*SAMPLE_W +: SAMPLE_W]`. Samples are queued in order of rising i, and words are queued in arrival order.
- R2: The buffer holds 2*NUM_CH samples. `s_ready` is high exactly when the buffer holds at most NUM_CH samples.
- R3: Suppose `rd_req` is high at an edge, `ch_en` has k ≥ 1 bits set, and at least k samples are buffered. Then `rd_valid` is high in the following cycle and exactly k samples leave the buffer.
- R4: In the cycle `rd_valid` is high, the j-th enabled channel, counted from index 0 upward, shows the j-th oldest of the removed samples on `ch_data[c*SAMPLE_W +: SAMPLE_W]`.
- R5: A read with k ≥ 1 enabled channels and fewer than k buffered samples gives `rd_underflow` high in the following cycle and removes no samples.
- R6: `rd_valid` and `rd_underflow` are never high together. Both are low in any cycle that does not follow an edge with `rd_req` high.
- R7: A read with `ch_en` all zero produces neither flag and removes no samples.
- R8: R3 to R5 hold for every one of the 2^NUM_CH enable masks. The mask is sampled at the same edge as `rd_req`.
- R9: A synchronous active-high `rst` empties the buffer and clears `rd_valid` and `rd_underflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input word present |
| s_ready | output | 1 | Buffer can take a whole word |
| s_data | input | NUM_CH*SAMPLE_W | Packed input samples, sample 0 in the low bits |
| rd_req | input | 1 | Shared read request |
| ch_en | input | NUM_CH | Per-channel enable mask |
| rd_valid | output | 1 | Previous read served |
| rd_underflow | output | 1 | Previous read lacked data |
| ch_data | output | NUM_CH*SAMPLE_W | Channel samples, meaningful on enabled channels while rd_valid is high |

## Verification
Some rules are checked by assertions on every cycle:
- the two response flags stay exclusive;
- both flags stay quiet after a cycle with no read, and after a read with an empty mask;
- the buffer fill level stays within bounds, and the buffer only accepts a word when there is room for it;
- a cycle that neither pushes nor pops leaves the fill level unchanged;
- reset empties the buffer.

Other behaviour only the bench scenarios can show, because it depends on data moving over many cycles: which sample lands on which channel, in what order, and whether a read is valid or underflow for a given fill level. The bench sweeps every enable mask through fill, drain and streaming phases, and also applies a reset in mid-stream.

// File: rtl/deint_pkg.sv
package deint_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_UNDER = 2'd2
  } rsp_e;
endpackage

// File: rtl/deint_sample_buf.sv
module deint_sample_buf #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 8,
  parameter int DEPTH    = 2 * NUM_CH,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [NUM_CH*SAMPLE_W-1:0]   in_word,
  input  logic [CW-1:0]                pop_n,
  output logic [CW-1:0]                count,
  output logic                         room,
  output logic [NUM_CH*SAMPLE_W-1:0]   head
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [SAMPLE_W-1:0] nxt [DEPTH];
  logic [CW-1:0]       count_nxt;

  assign room = (count <= CW'(DEPTH - NUM_CH));

  always_comb begin
    int base;
    base = int'(count) - int'(pop_n);
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_n) < DEPTH) nxt[i] = mem[i + int'(pop_n)];
      else                         nxt[i] = '0;
      if (push) begin
        for (int j = 0; j < NUM_CH; j++) begin
          if (i == base + j) nxt[i] = in_word[j*SAMPLE_W +: SAMPLE_W];
        end
      end
    end
    count_nxt = count - pop_n + (push ? CW'(NUM_CH) : CW'(0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      count <= count_nxt;
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_head
      assign head[g*SAMPLE_W +: SAMPLE_W] = mem[g];
    end
  endgenerate

  a_r2_bound: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
  a_r2_room_on_push: assert property (@(posedge clk) disable iff (rst)
    push |-> count <= CW'(DEPTH - NUM_CH));
  a_r3_no_underrun: assert property (@(posedge clk) disable iff (rst) pop_n <= count);
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (pop_n == '0 && !push) |=> $stable(count));
  a_r9_empty: assert property (@(posedge clk) rst |=> count == '0);
endmodule

// File: rtl/deint_router.sv
module deint_router #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 8,
  parameter int CW       = 4
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] head,
  input  logic [NUM_CH-1:0]          en,
  output logic [NUM_CH*SAMPLE_W-1:0] routed,
  output logic [CW-1:0]              k
);
  always_comb begin
    int run;
    run = 0;
    routed = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (en[c]) begin
        routed[c*SAMPLE_W +: SAMPLE_W] = head[run*SAMPLE_W +: SAMPLE_W];
        run = run + 1;
      end
    end
    k = CW'(run);
  end
endmodule

// File: rtl/deint_resp.sv
module deint_resp
  import deint_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 8,
  parameter int CW       = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_req,
  input  logic [CW-1:0]              k,
  input  logic [CW-1:0]              count,
  input  logic [NUM_CH*SAMPLE_W-1:0] routed,
  output logic                       take,
  output logic                       valid,
  output logic                       underflow,
  output logic [NUM_CH*SAMPLE_W-1:0] data
);
  rsp_e rsp_q, rsp_d;

  assign take = rd_req && (k != '0) && (count >= k);

  always_comb begin
    if (!rd_req || k == '0) rsp_d = RSP_NONE;
    else if (take)          rsp_d = RSP_DATA;
    else                    rsp_d = RSP_UNDER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q <= RSP_NONE;
      data  <= '0;
    end else begin
      rsp_q <= rsp_d;
      if (take) data <= routed;
    end
  end

  assign valid     = (rsp_q == RSP_DATA);
  assign underflow = (rsp_q == RSP_UNDER);

  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst) !(valid && underflow));
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!valid && !underflow));
  a_r7_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (rd_req && k == '0) |=> (!valid && !underflow));
  a_r9_flags: assert property (@(posedge clk) rst |=> (!valid && !underflow));
endmodule

// File: rtl/stream_deinterleaver.sv
module stream_deinterleaver #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [NUM_CH*SAMPLE_W-1:0] s_data,
  input  logic                       rd_req,
  input  logic [NUM_CH-1:0]          ch_en,
  output logic                       rd_valid,
  output logic                       rd_underflow,
  output logic [NUM_CH*SAMPLE_W-1:0] ch_data
);
  localparam int DEPTH = 2 * NUM_CH;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [CW-1:0]              count, k, pop_n;
  logic [NUM_CH*SAMPLE_W-1:0] head, routed;
  logic                       take, push;

  assign push  = s_valid && s_ready;
  assign pop_n = take ? k : '0;

  deint_sample_buf #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .push(push), .in_word(s_data), .pop_n(pop_n),
    .count(count), .room(s_ready), .head(head)
  );

  deint_router #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CW(CW)) u_route (
    .head(head), .en(ch_en), .routed(routed), .k(k)
  );

  deint_resp #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CW(CW)) u_resp (
    .clk(clk), .rst(rst), .rd_req(rd_req), .k(k), .count(count), .routed(routed),
    .take(take), .valid(rd_valid), .underflow(rd_underflow), .data(ch_data)
  );
endmodule

// File: tb/sim_stream_deinterleaver.sv
`timescale 1ns/1ps
module sim_stream_deinterleaver;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 0;
  logic rst = 1;
  logic s_valid = 0;
  logic s_ready;
  logic [N*W-1:0] s_data = '0;
  logic rd_req = 0;
  logic [N-1:0] ch_en = '0;
  logic rd_valid, rd_underflow;
  logic [N*W-1:0] ch_data;

  always #4 clk = ~clk;

  stream_deinterleaver #(.NUM_CH(N), .SAMPLE_W(W)) u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .rd_req(rd_req), .ch_en(ch_en), .rd_valid(rd_valid), .rd_underflow(rd_underflow),
    .ch_data(ch_data)
  );

  int tests = 0, fails = 0;
  logic [W-1:0] q [4096];
  int head = 0, tail = 0;
  logic [W-1:0] gen = 8'h10;
  logic exp_v = 0, exp_u = 0;
  logic [N-1:0] exp_mask = '0;
  logic [W-1:0] exp_d [N];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_prev();
    chk(rd_valid == exp_v, "R3 rd_valid", rd_valid, exp_v);
    chk(rd_underflow == exp_u, "R5 rd_underflow", rd_underflow, exp_u);
    chk(!(rd_valid && rd_underflow), "R6 exclusive", {rd_valid, rd_underflow}, 0);
    if (exp_v) begin
      for (int c = 0; c < N; c++)
        if (exp_mask[c])
          chk(ch_data[c*W +: W] == exp_d[c], "R4 R8 channel data",
              ch_data[c*W +: W], exp_d[c]);
    end
  endtask

  // one cycle: called right after a falling edge
  task automatic step(input logic sv, input logic rd, input logic [N-1:0] m);
    int k, avail, j;
    check_prev();
    s_valid = sv;
    s_data  = {gen + 8'd3, gen + 8'd2, gen + 8'd1, gen};
    rd_req  = rd;
    ch_en   = m;
    #1;
    avail = tail - head;
    chk(s_ready == (avail <= N), "R2 s_ready", s_ready, avail <= N);
    k = $countones(m);
    exp_v = 0; exp_u = 0; exp_mask = m;
    if (rd && k != 0) begin
      if (avail >= k) begin
        exp_v = 1; j = 0;
        for (int c = 0; c < N; c++)
          if (m[c]) begin exp_d[c] = q[(head + j) % 4096]; j++; end
        head += k;
      end else exp_u = 1;
    end
    if (sv && s_ready) begin  // R1 queue order
      for (int i = 0; i < N; i++) q[(tail + i) % 4096] = gen + 8'(i);
      tail += N;
      gen += 8'(N);
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    chk(rd_valid == 0 && rd_underflow == 0, "R9 reset flags", {rd_valid, rd_underflow}, 0);
    chk(s_ready == 1, "R9 reset ready", s_ready, 1);
    // R7 empty mask read, R5 read on empty buffer
    step(0, 1, 4'b0000);
    step(0, 1, 4'b0001);
    step(0, 0, 4'b1111);  // R6 quiet after no read
    for (int m = 0; m < (1 << N); m++) begin  // R8 sweep all masks
      for (int t = 0; t < 48; t++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (t < 24)      step(lfsr[0], lfsr[1] | lfsr[2], 4'(m));
        else if (t < 36) step(0, 1, 4'(m));
        else             step(1, lfsr[3] | lfsr[4] | lfsr[5], 4'(m));
      end
      step(1, 0, 4'(m));
    end
    // R9 reset in mid-stream
    step(1, 0, 4'b1111);
    step(1, 0, 4'b1111);
    check_prev();
    rst = 1; rd_req = 0; s_valid = 0;
    @(negedge clk);
    rst = 0;
    head = 0; tail = 0; exp_v = 0; exp_u = 0;
    chk(rd_valid == 0 && rd_underflow == 0, "R9 flags after reset", {rd_valid, rd_underflow}, 0);
    chk(s_ready == 1, "R9 empty after reset", s_ready, 1);
    step(0, 1, 4'b0001);  // must underflow
    chk(exp_u == 1, "R9 model underflow expected", exp_u, 1);
    step(0, 0, 4'b0000);
    check_prev();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule